// File: doc/BRIEF.md
# Exception Entry Control Unit

This block applies the control-register side effects of a 64-bit processor taking an exception. When the pipeline raises a request, the unit takes the cause, the PC of the faulting instruction, a flag telling whether that instruction sits in a branch delay slot, the faulting address, and a base offset. In one clock edge it updates the saved exception PC, the branch-delay flag, the cause code, the coprocessor-number field and the exception-level flag. It also updates the faulting-address register and the translation-context fields.

One cycle after the request, the unit emits a redirect pulse with the 64-bit target PC. The target is a vector base, chosen by the boot-vector input, plus a cause-dependent offset, minus the supplied base offset. An exception-return pulse clears the exception-level flag. Only one request is accepted per cycle.

Top module: `exc_entry_unit`

## Requirements
- R1: When a known request arrives while the exception-level flag is clear, the saved PC becomes req_pc and cause_bd becomes 0 if req_in_delay is 0. If req_in_delay is 1, the saved PC becomes req_pc minus 4 and cause_bd becomes 1. Both update at the clock edge that samples the request.
- R2: When a request arrives while the exception-level flag is already set, the saved PC and cause_bd keep their values.
- R3: The redirect target is base + offset - base_offset. The base is 0xFFFFFFFFBFC00200 when boot_vec is 1 and 0xFFFFFFFF80000000 when it is 0. The offset is 0x180 whenever the exception-level flag was already set. Otherwise the offset is 0x080 for causes 14 and 15, 0x280 for cause 13, and 0x180 for every other cause.
- R4: req_cause is encoded as follows: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 syscall, 7 breakpoint, 8 reserved instruction, 9 coprocessor unusable, 10 overflow, 11 trap, 12 coprocessor-2 exception, 13 capability trap, 14 64-bit refill load, 15 64-bit refill store, 16 64-bit invalid load, 17 64-bit invalid store, 18 machine check. The 5-bit cause_code then reads, in that order: 0x00, 0x01, 0x02, 0x03, 0x04, 0x05, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x12, 0x12, 0x02, 0x03, 0x02, 0x03, 0x18.
- R5: Every accepted request sets the exception-level flag. An exl_clear pulse without a request clears it. When both occur in the same cycle, the request wins and the flag stays set.
- R6: Causes 1 to 5 and 14 to 17 load req_bad_addr into bad_vaddr. All other causes leave bad_vaddr unchanged.
- R7: The TLB causes (1, 2, 3, 14 to 17) update the context fields. Address bits 31..13 go to ctx_vpn_field. Bits 39..13 go to xctx_vpn_field and hi_vpn. Bits 63..62 go to xctx_region and hi_region. All other causes leave these fields unchanged.
- R8: A coprocessor-unusable request (cause 9) leaves cause_ce at 0 after its clock edge.
- R9: redirect_valid is high for exactly the one cycle after each accepted request, and redirect_pc carries the target in that cycle.
- R10: A request with a cause value of 19 to 31 is ignored: no redirect and no state change.
- R11: After reset, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request |
| req_cause | input | 5 | Cause encoding (see R4) |
| req_pc | input | 64 | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| req_bad_addr | input | 64 | Faulting virtual address |
| base_offset | input | 64 | Value subtracted from the target |
| boot_vec | input | 1 | Selects the boot vector base |
| exl_clear | input | 1 | Exception-return pulse |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | 64 | Redirect target |
| epc | output | 64 | Saved exception PC |
| cause_bd | output | 1 | Branch-delay flag |
| cause_ce | output | 2 | Coprocessor-number field |
| cause_code | output | 5 | Exception code |
| exl | output | 1 | Exception-level flag |
| bad_vaddr | output | 64 | Faulting-address register |
| ctx_vpn_field | output | 19 | Context page number field |
| xctx_vpn_field | output | 27 | Extended-context page number field |
| xctx_region | output | 2 | Extended-context region field |
| hi_vpn | output | 27 | Entry-high page number field |
| hi_region | output | 2 | Entry-high region field |

## Verification
The bench sweeps all 32 cause values against both states of the exception-level flag, both vector bases and both delay-slot settings. It checks every output after each request.

The sweep targets several specific faults:
- A unit that captured the PC while already at exception level would overwrite the saved PC that a nested handler needs.
- A unit that dropped the minus-4 correction would resume past the branch.
- A unit that chose the refill or capability offset while at exception level would jump to the wrong handler.
- Codes 19 to 31 probe the ignore path; a design without that filter would redirect on garbage.
- Non-TLB causes with fresh address patterns show whether the faulting-address and context fields are written too broadly.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CAUSE_W     = 5;
  localparam int CODE_W      = 5;
  localparam int OFF_W       = 12;
  localparam int CAUSE_COUNT = 19;

  localparam logic [CAUSE_W-1:0] C_INT     = 5'd0;
  localparam logic [CAUSE_W-1:0] C_TLBMOD  = 5'd1;
  localparam logic [CAUSE_W-1:0] C_TLBLD   = 5'd2;
  localparam logic [CAUSE_W-1:0] C_TLBST   = 5'd3;
  localparam logic [CAUSE_W-1:0] C_ADRLD   = 5'd4;
  localparam logic [CAUSE_W-1:0] C_ADRST   = 5'd5;
  localparam logic [CAUSE_W-1:0] C_SYSC    = 5'd6;
  localparam logic [CAUSE_W-1:0] C_BRK     = 5'd7;
  localparam logic [CAUSE_W-1:0] C_RSVD    = 5'd8;
  localparam logic [CAUSE_W-1:0] C_COPU    = 5'd9;
  localparam logic [CAUSE_W-1:0] C_OVF     = 5'd10;
  localparam logic [CAUSE_W-1:0] C_TRAP    = 5'd11;
  localparam logic [CAUSE_W-1:0] C_COP2    = 5'd12;
  localparam logic [CAUSE_W-1:0] C_CAPTRAP = 5'd13;
  localparam logic [CAUSE_W-1:0] C_XREFLD  = 5'd14;
  localparam logic [CAUSE_W-1:0] C_XREFST  = 5'd15;
  localparam logic [CAUSE_W-1:0] C_XINVLD  = 5'd16;
  localparam logic [CAUSE_W-1:0] C_XINVST  = 5'd17;
  localparam logic [CAUSE_W-1:0] C_MCHK    = 5'd18;

  localparam logic [OFF_W-1:0] OFF_COMMON  = 12'h180;
  localparam logic [OFF_W-1:0] OFF_REFILL  = 12'h080;
  localparam logic [OFF_W-1:0] OFF_CAPTRAP = 12'h280;

  function automatic logic cause_known(input logic [CAUSE_W-1:0] c);
    return (32'(c) < CAUSE_COUNT);
  endfunction

  function automatic logic cause_is_tlb(input logic [CAUSE_W-1:0] c);
    return (c inside {C_TLBMOD, C_TLBLD, C_TLBST, C_XREFLD, C_XREFST, C_XINVLD, C_XINVST});
  endfunction

  function automatic logic cause_is_addr_err(input logic [CAUSE_W-1:0] c);
    return (c == C_ADRLD) || (c == C_ADRST);
  endfunction

  function automatic logic [CODE_W-1:0] code_of(input logic [CAUSE_W-1:0] c);
    logic [CODE_W-1:0] r;
    case (c)
      C_INT:     r = 5'h00;
      C_TLBMOD:  r = 5'h01;
      C_TLBLD:   r = 5'h02;
      C_TLBST:   r = 5'h03;
      C_ADRLD:   r = 5'h04;
      C_ADRST:   r = 5'h05;
      C_SYSC:    r = 5'h08;
      C_BRK:     r = 5'h09;
      C_RSVD:    r = 5'h0A;
      C_COPU:    r = 5'h0B;
      C_OVF:     r = 5'h0C;
      C_TRAP:    r = 5'h0D;
      C_COP2:    r = 5'h12;
      C_CAPTRAP: r = 5'h12;
      C_XREFLD:  r = 5'h02;
      C_XREFST:  r = 5'h03;
      C_XINVLD:  r = 5'h02;
      C_XINVST:  r = 5'h03;
      C_MCHK:    r = 5'h18;
      default:   r = 5'h00;
    endcase
    return r;
  endfunction

  function automatic logic [OFF_W-1:0] vec_offset(input logic [CAUSE_W-1:0] c,
                                                   input logic already_exl);
    logic [OFF_W-1:0] r;
    if (already_exl)                             r = OFF_COMMON;
    else if (c == C_XREFLD || c == C_XREFST)     r = OFF_REFILL;
    else if (c == C_CAPTRAP)                     r = OFF_CAPTRAP;
    else                                         r = OFF_COMMON;
    return r;
  endfunction

endpackage

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter logic [63:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic               cur_exl,
  input  logic               boot_vec,
  input  logic [XLEN-1:0]    base_offset,
  output logic [XLEN-1:0]    target
);
  localparam int EXT_W = XLEN - OFF_W;

  logic [OFF_W-1:0] off;
  logic [XLEN-1:0]  off_sext;
  logic [XLEN-1:0]  base_sel;

  always_comb begin
    off      = vec_offset(cause, cur_exl);
    off_sext = {{EXT_W{off[OFF_W-1]}}, off};
    base_sel = boot_vec ? BOOT_BASE[XLEN-1:0] : NORM_BASE[XLEN-1:0];
    target   = base_sel + off_sext - base_offset;
  end
endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    pc,
  input  logic               in_delay,
  input  logic               exl_clear,
  output logic [XLEN-1:0]    epc,
  output logic               bd,
  output logic [1:0]         ce,
  output logic [CODE_W-1:0]  code,
  output logic               exl
);
  logic capture_pc;
  logic clear_ce;
  logic drop_exl;

  assign capture_pc = take && !exl;
  assign clear_ce   = take && (cause == C_COPU);
  assign drop_exl   = exl_clear && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc  <= '0;
      bd   <= 1'b0;
      ce   <= 2'b00;
      code <= '0;
      exl  <= 1'b0;
    end else begin
      if (capture_pc) begin
        epc <= in_delay ? (pc - XLEN'(4)) : pc;
        bd  <= in_delay;
      end
      if (take) code <= code_of(cause);
      if (clear_ce) ce <= 2'b00;
      if (take) exl <= 1'b1;
      else if (drop_exl) exl <= 1'b0;
    end
  end

  // R1
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_pc |=> (epc == ($past(in_delay) ? $past(pc) - XLEN'(4) : $past(pc)))
                   && (bd == $past(in_delay)));
  // R2
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && exl) |=> ($stable(epc) && $stable(bd)));
  // R5
  exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> exl);
  // R5
  exl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_exl |=> !exl);
  // R8
  ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_ce |=> (ce == 2'b00));
endmodule

// File: rtl/exc_ctx_capture.sv
module exc_ctx_capture
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int VPN_LO  = 13,
  parameter int CTX_HI  = 31,
  parameter int XCTX_HI = 39
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [CAUSE_W-1:0]            cause,
  input  logic [XLEN-1:0]               bad_addr,
  output logic [XLEN-1:0]               bad_vaddr,
  output logic [CTX_HI-VPN_LO:0]        ctx_vpn,
  output logic [XCTX_HI-VPN_LO:0]       xctx_vpn,
  output logic [1:0]                    xctx_region,
  output logic [XCTX_HI-VPN_LO:0]       hi_vpn,
  output logic [1:0]                    hi_region
);
  localparam int CTX_W  = CTX_HI - VPN_LO + 1;
  localparam int XCTX_W = XCTX_HI - VPN_LO + 1;

  logic save_addr;
  logic save_ctx;

  assign save_ctx  = take && cause_is_tlb(cause);
  assign save_addr = save_ctx || (take && cause_is_addr_err(cause));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_vaddr   <= '0;
      ctx_vpn     <= '0;
      xctx_vpn    <= '0;
      xctx_region <= 2'b00;
      hi_vpn      <= '0;
      hi_region   <= 2'b00;
    end else begin
      if (save_addr) bad_vaddr <= bad_addr;
      if (save_ctx) begin
        ctx_vpn     <= bad_addr[CTX_HI:VPN_LO];
        xctx_vpn    <= bad_addr[XCTX_HI:VPN_LO];
        xctx_region <= bad_addr[XLEN-1:XLEN-2];
        hi_vpn      <= bad_addr[XCTX_HI:VPN_LO];
        hi_region   <= bad_addr[XLEN-1:XLEN-2];
      end
    end
  end

  // R6
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_addr |=> $stable(bad_vaddr));
  // R6
  bad_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_addr |=> (bad_vaddr == $past(bad_addr)));
  // R7
  ctx_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_vpn == xctx_vpn[CTX_W-1:0]) && (hi_vpn == xctx_vpn) && (hi_region == xctx_region));
  // R7
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !save_ctx |=> ($stable(xctx_vpn) && $stable(xctx_region)));
  // R7
  xctx_width_chk: assert final (XCTX_W >= CTX_W);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter int          VPN_LO    = 13,
  parameter int          CTX_HI    = 31,
  parameter int          XCTX_HI   = 39,
  parameter logic [63:0] BOOT_BASE = 64'hFFFF_FFFF_BFC0_0200,
  parameter logic [63:0] NORM_BASE = 64'hFFFF_FFFF_8000_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [4:0]              req_cause,
  input  logic [XLEN-1:0]         req_pc,
  input  logic                    req_in_delay,
  input  logic [XLEN-1:0]         req_bad_addr,
  input  logic [XLEN-1:0]         base_offset,
  input  logic                    boot_vec,
  input  logic                    exl_clear,
  output logic                    redirect_valid,
  output logic [XLEN-1:0]         redirect_pc,
  output logic [XLEN-1:0]         epc,
  output logic                    cause_bd,
  output logic [1:0]              cause_ce,
  output logic [4:0]              cause_code,
  output logic                    exl,
  output logic [XLEN-1:0]         bad_vaddr,
  output logic [CTX_HI-VPN_LO:0]  ctx_vpn_field,
  output logic [XCTX_HI-VPN_LO:0] xctx_vpn_field,
  output logic [1:0]              xctx_region,
  output logic [XCTX_HI-VPN_LO:0] hi_vpn,
  output logic [1:0]              hi_region
);
  logic            accept;
  logic            reject;
  logic [XLEN-1:0] target;

  assign accept = req_valid && cause_known(req_cause);
  assign reject = req_valid && !cause_known(req_cause);

  exc_vector_gen #(.XLEN(XLEN), .BOOT_BASE(BOOT_BASE), .NORM_BASE(NORM_BASE)) u_vec (
    .cause(req_cause), .cur_exl(exl), .boot_vec(boot_vec),
    .base_offset(base_offset), .target(target));

  exc_status_regs #(.XLEN(XLEN)) u_stat (
    .clk(clk), .rst_n(rst_n), .take(accept), .cause(req_cause), .pc(req_pc),
    .in_delay(req_in_delay), .exl_clear(exl_clear), .epc(epc), .bd(cause_bd),
    .ce(cause_ce), .code(cause_code), .exl(exl));

  exc_ctx_capture #(.XLEN(XLEN), .VPN_LO(VPN_LO), .CTX_HI(CTX_HI), .XCTX_HI(XCTX_HI)) u_ctx (
    .clk(clk), .rst_n(rst_n), .take(accept), .cause(req_cause), .bad_addr(req_bad_addr),
    .bad_vaddr(bad_vaddr), .ctx_vpn(ctx_vpn_field), .xctx_vpn(xctx_vpn_field),
    .xctx_region(xctx_region), .hi_vpn(hi_vpn), .hi_region(hi_region));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= accept;
      if (accept) redirect_pc <= target;
    end
  end

  // R9
  redirect_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> redirect_valid);
  // R9
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !redirect_valid);
  // R10
  reject_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !exl_clear) |=> ($stable(epc) && $stable(exl) && $stable(cause_code)
                                && $stable(bad_vaddr) && !redirect_valid));
  // R3
  captrap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !exl && req_cause == C_CAPTRAP && !boot_vec)
      |=> (redirect_pc == NORM_BASE[XLEN-1:0] + XLEN'(12'h280) - $past(base_offset)));
  // R3
  nested_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && exl && boot_vec)
      |=> (redirect_pc == BOOT_BASE[XLEN-1:0] + XLEN'(12'h180) - $past(base_offset)));
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_cause = '0;
  logic [63:0] req_pc = '0;
  logic        req_in_delay = 1'b0;
  logic [63:0] req_bad_addr = '0;
  logic [63:0] base_offset = '0;
  logic        boot_vec = 1'b0;
  logic        exl_clear = 1'b0;
  logic        redirect_valid;
  logic [63:0] redirect_pc;
  logic [63:0] epc;
  logic        cause_bd;
  logic [1:0]  cause_ce;
  logic [4:0]  cause_code;
  logic        exl;
  logic [63:0] bad_vaddr;
  logic [18:0] ctx_vpn_field;
  logic [26:0] xctx_vpn_field;
  logic [1:0]  xctx_region;
  logic [26:0] hi_vpn;
  logic [1:0]  hi_region;

  int checks = 0;
  int failures = 0;

  logic [63:0] m_epc = 0, m_bad = 0;
  logic        m_bd = 0, m_exl = 0;
  logic [4:0]  m_code = 0;
  logic [18:0] m_ctx = 0;
  logic [26:0] m_xctx = 0;
  logic [1:0]  m_reg = 0;

  always #5 clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
    .req_pc(req_pc), .req_in_delay(req_in_delay), .req_bad_addr(req_bad_addr),
    .base_offset(base_offset), .boot_vec(boot_vec), .exl_clear(exl_clear),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .epc(epc),
    .cause_bd(cause_bd), .cause_ce(cause_ce), .cause_code(cause_code), .exl(exl),
    .bad_vaddr(bad_vaddr), .ctx_vpn_field(ctx_vpn_field), .xctx_vpn_field(xctx_vpn_field),
    .xctx_region(xctx_region), .hi_vpn(hi_vpn), .hi_region(hi_region));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code(input int c);
    case (c)
      0: return 5'h00;   1: return 5'h01;   2: return 5'h02;   3: return 5'h03;
      4: return 5'h04;   5: return 5'h05;   6: return 5'h08;   7: return 5'h09;
      8: return 5'h0A;   9: return 5'h0B;  10: return 5'h0C;  11: return 5'h0D;
      12: return 5'h12; 13: return 5'h12;  14: return 5'h02;  15: return 5'h03;
      16: return 5'h02; 17: return 5'h03;  18: return 5'h18;
      default: return 5'h00;
    endcase
  endfunction

  task automatic check_state(input string tag);
    chk(epc, m_epc, {tag, " R1/R2 epc"});
    chk(64'(cause_bd), 64'(m_bd), {tag, " R1/R2 bd"});
    chk(64'(cause_code), 64'(m_code), {tag, " R4 code"});
    chk(64'(exl), 64'(m_exl), {tag, " R5 exl"});
    chk(bad_vaddr, m_bad, {tag, " R6 bad_vaddr"});
    chk(64'(ctx_vpn_field), 64'(m_ctx), {tag, " R7 ctx"});
    chk(64'(xctx_vpn_field), 64'(m_xctx), {tag, " R7 xctx"});
    chk(64'(hi_vpn), 64'(m_xctx), {tag, " R7 hi_vpn"});
    chk(64'(xctx_region), 64'(m_reg), {tag, " R7 xregion"});
    chk(64'(hi_region), 64'(m_reg), {tag, " R7 hi_region"});
    chk(64'(cause_ce), 64'd0, {tag, " R8 ce"});
  endtask

  task automatic fire(input int c, input logic [63:0] pc, input logic dly,
                      input logic [63:0] bad, input logic [63:0] kofs, input logic bv);
    logic        known;
    logic [63:0] off, tgt;
    @(negedge clk);
    req_valid = 1'b1; req_cause = 5'(c); req_pc = pc; req_in_delay = dly;
    req_bad_addr = bad; base_offset = kofs; boot_vec = bv;
    known = (c < 19);
    if (m_exl) off = 64'h180;
    else if (c == 14 || c == 15) off = 64'h080;
    else if (c == 13) off = 64'h280;
    else off = 64'h180;
    tgt = (bv ? 64'hFFFF_FFFF_BFC0_0200 : 64'hFFFF_FFFF_8000_0000) + off - kofs;
    if (known) begin
      if (!m_exl) begin
        m_epc = dly ? pc - 64'd4 : pc;
        m_bd  = dly;
      end
      m_code = exp_code(c);
      if ((c >= 1 && c <= 5) || (c >= 14 && c <= 17)) m_bad = bad;
      if ((c >= 1 && c <= 3) || (c >= 14 && c <= 17)) begin
        m_ctx  = bad[31:13];
        m_xctx = bad[39:13];
        m_reg  = bad[63:62];
      end
      m_exl = 1'b1;
    end
    @(negedge clk);
    chk(64'(redirect_valid), 64'(known), $sformatf("cause %0d R9/R10 redirect_valid", c));
    if (known) chk(redirect_pc, tgt, $sformatf("cause %0d exl %0d bev %0d R3 target", c, off == 64'h180, bv));
    check_state($sformatf("cause %0d", c));
    req_valid = 1'b0;
    @(negedge clk);
    chk(64'(redirect_valid), 64'd0, "R9 single-cycle pulse");
  endtask

  task automatic clear_exl();
    @(negedge clk);
    exl_clear = 1'b1;
    @(negedge clk);
    exl_clear = 1'b0;
    m_exl = 1'b0;
    chk(64'(exl), 64'd0, "R5 exl_clear");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(64'(redirect_valid), 64'd0, "R11 redirect_valid");
    chk(redirect_pc, 64'd0, "R11 redirect_pc");
    check_state("R11 reset");
    rst_n = 1'b1;
    idx = 0;
    for (int c = 0; c < 32; c++) begin
      for (int e = 0; e < 2; e++) begin
        for (int bv = 0; bv < 2; bv++) begin
          for (int dl = 0; dl < 2; dl++) begin
            logic [63:0] pc, bad, kofs;
            pc   = 64'h0000_0040_0000_1000 + (64'(idx) << 4) + (64'(idx) << 48);
            bad  = 64'h5A5A_0123_4567_8000 ^ (64'(idx) * 64'h0101_0101_0101_2001);
            kofs = 64'(idx) << 8;
            if (e == 1) fire(6, pc ^ 64'h100, 1'b0, 64'h0, 64'h0, 1'b0);
            else clear_exl();
            fire(c, pc, dl[0], bad, kofs, bv[0]);
            idx++;
          end
        end
      end
    end
    // R5 simultaneous clear and request: request wins
    clear_exl();
    @(negedge clk);
    req_valid = 1'b1; req_cause = 5'd7; exl_clear = 1'b1;
    req_pc = 64'h1000; req_in_delay = 1'b0;
    m_epc = 64'h1000; m_bd = 1'b0; m_code = 5'h09; m_exl = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; exl_clear = 1'b0;
    chk(64'(exl), 64'd1, "R5 request beats clear");
    check_state("R5 simultaneous");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule